// File: doc/BRIEF.md
# Serial Flash Command and Status Front End

This block is the slave-side command decoder of a small serial flash. It watches the four serial pins, chip enable (active low), serial clock, serial data in and serial data out, from a faster system clock. It works with either of the usual idle clock levels: clock low (mode 0) or clock high (mode 3). Opcodes are shifted in most significant bit first on rising serial clock edges. Every command except the status read acts only when chip enable returns high after exactly eight opcode bits.

Three commands are supported. One sets the write-enable latch. Two opcodes ask for a chip erase. One streams the status byte out. An accepted erase starts a self-timed cycle of a parameterised number of system clocks. During that cycle the busy flag is raised, and at its end the storage stub is filled with ones. A block-protect input that is not all zero turns an erase request into a silent rejection. So does a cleared write-enable latch. The storage is a small register file with a local port that loads and observes it.

Top module: `spif_cmd_ctrl`

## Requirements
- R1: After reset the serial output enable is low, the write-enable latch and busy flag are 0, and every storage byte reads 0x00.
- R2: Serial input is sampled MSB first on rising serial clock edges, and commands behave the same whether the clock idles low (mode 0) or high (mode 3) when chip enable falls.
- R3: Opcode 0x05 returns the status byte MSB first, with bit 0 = busy, bit 1 = write-enable latch, bits 5:2 = block-protect input bits 3:0, and bits 7:6 = 0. The first bit is driven on the first falling clock edge after the eighth opcode bit.
- R4: The status byte repeats every eight further clocks until chip enable rises.
- R5: The serial output enable is low while chip enable is high and during opcode input.
- R6: Opcode 0x06 sets the write-enable latch once chip enable rises.
- R7: Opcodes 0x60 and 0xC7 both start an erase when the write-enable latch is 1 and the block-protect input is zero. The busy flag then reads 1.
- R8: An erase request with a nonzero block-protect input, or with the latch at 0, is dropped: storage is unchanged and the latch is cleared.
- R9: An erase holds busy for TCE_CYCLES system clocks. It then sets every storage byte to 0xFF and clears both busy and the write-enable latch.
- R10: While busy is 1, every opcode other than 0x05 is ignored, and the status byte can still be read.
- R11: A command is discarded when chip enable rises after any bit count other than eight.
- R12: Opcodes outside 0x05, 0x06, 0x60 and 0xC7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_ni | input | 1 | Serial chip enable, active low |
| sck_i | input | 1 | Serial clock |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out value |
| so_oe_o | output | 1 | Serial data out enable (0 means high impedance) |
| bp_i | input | 4 | Block-protect bits |
| arr_we_i | input | 1 | Storage stub write strobe |
| arr_addr_i | input | ARR_AW | Storage stub address |
| arr_wdata_i | input | 8 | Storage stub write data |
| arr_rdata_o | output | 8 | Storage stub read data |

## Verification
The bench targets command framing. It sends seven-bit and nine-bit opcodes, and a design that decoded on the eighth edge instead of on chip-enable release would wrongly set the latch or start an erase. It sends erase requests with protection set or the latch clear. A wrong design would wipe the storage or leave a stale latch bit visible in the status byte. It also sends an erase request during a running erase with protection raised. A design that failed to block commands while busy would clear the latch in the middle of the cycle. Status reads run for up to three bytes in both clock modes, which exposes an off-by-one-edge output shift or a byte that does not repeat.

// File: rtl/spif_pkg.sv
package spif_pkg;
  localparam int BP_W = 4;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_ERA_A = 8'h60;
  localparam logic [7:0] OP_ERA_B = 8'hC7;

  function automatic logic [7:0] status_byte(logic [BP_W-1:0] bp, logic wel, logic busy);
    return {2'b00, bp, wel, busy};
  endfunction
endpackage

// File: rtl/spif_sync.sv
module spif_sync #(
  parameter int          W        = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
      prev_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign q_o    = sync_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/spif_shift.sv
module spif_shift
  import spif_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ce_q_i,
  input  logic       sck_rise_i,
  input  logic       sck_fall_i,
  input  logic       si_q_i,
  input  logic [7:0] status_i,
  output logic [7:0] opcode_o,
  output logic [3:0] bits_o,
  output logic       so_o,
  output logic       so_oe_o
);
  logic [7:0] opc_q, out_q;
  logic [3:0] bits_q;
  logic [2:0] idx_q;
  logic       so_q, oe_q;
  logic       rd_mode;

  assign rd_mode = (bits_q == 4'd8) && (opc_q == OP_RDSR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opc_q  <= '0;
      bits_q <= '0;
      out_q  <= '0;
      idx_q  <= '0;
      so_q   <= 1'b0;
      oe_q   <= 1'b0;
    end else if (ce_q_i) begin
      bits_q <= '0;
      idx_q  <= '0;
      oe_q   <= 1'b0;
      so_q   <= 1'b0;
    end else if (rd_mode) begin
      if (sck_fall_i) begin
        // reload live status at every byte boundary
        if (idx_q == 3'd0) begin
          so_q  <= status_i[7];
          out_q <= {status_i[6:0], 1'b0};
        end else begin
          so_q  <= out_q[7];
          out_q <= {out_q[6:0], 1'b0};
        end
        idx_q <= idx_q + 3'd1;
        oe_q  <= 1'b1;
      end
    end else if (sck_rise_i) begin
      opc_q <= {opc_q[6:0], si_q_i};
      if (bits_q != 4'hF) bits_q <= bits_q + 4'd1;
    end
  end

  assign opcode_o = opc_q;
  assign bits_o   = bits_q;
  assign so_o     = so_q;
  assign so_oe_o  = oe_q;
endmodule

// File: rtl/spif_ctrl.sv
module spif_ctrl
  import spif_pkg::*;
#(
  parameter int TCE_CYCLES = 4096,
  localparam int CW = $clog2(TCE_CYCLES + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ce_rise_i,
  input  logic [7:0]      opcode_i,
  input  logic [3:0]      bits_i,
  input  logic [BP_W-1:0] bp_i,
  output logic            busy_o,
  output logic            wel_o,
  output logic            erase_start_o,
  output logic            erase_done_o
);
  logic [CW-1:0] cnt_q;
  logic          busy_q, wel_q;
  logic          cmd_ok, is_wren, is_erase, erase_rej;

  assign cmd_ok        = ce_rise_i && (bits_i == 4'd8) && !busy_q;
  assign is_wren       = (opcode_i == OP_WREN);
  assign is_erase      = (opcode_i == OP_ERA_A) || (opcode_i == OP_ERA_B);
  assign erase_start_o = cmd_ok && is_erase && wel_q && (bp_i == '0);
  assign erase_rej     = cmd_ok && is_erase && !erase_start_o;
  assign erase_done_o  = busy_q && (cnt_q == CW'(TCE_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      wel_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (erase_start_o) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (erase_done_o) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        cnt_q  <= cnt_q + CW'(1);
      end
      if (erase_done_o || erase_rej) wel_q <= 1'b0;
      else if (cmd_ok && is_wren)    wel_q <= 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign wel_o  = wel_q;
endmodule

// File: rtl/spif_array.sv
module spif_array #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          erase_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          mem_q[g] <= 8'h00;
      else if (erase_i)                     mem_q[g] <= 8'hFF;
      else if (we_i && addr_i == AW'(g))    mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/spif_cmd_ctrl.sv
module spif_cmd_ctrl
  import spif_pkg::*;
#(
  parameter int TCE_CYCLES = 4096,
  parameter int ARR_DEPTH  = 16,
  localparam int ARR_AW    = $clog2(ARR_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              sck_i,
  input  logic              si_i,
  output logic              so_o,
  output logic              so_oe_o,
  input  logic [BP_W-1:0]   bp_i,
  input  logic              arr_we_i,
  input  logic [ARR_AW-1:0] arr_addr_i,
  input  logic [7:0]        arr_wdata_i,
  output logic [7:0]        arr_rdata_o
);
  logic [2:0] pin_q, pin_prev;
  logic       ce_q, ce_prev, sck_q, sck_prev, si_q;
  logic       ce_rise, sck_rise, sck_fall;
  logic [7:0] opcode, status;
  logic [3:0] bits;
  logic       busy, wel, erase_start, erase_done;

  // pin order {ce, sck, si}
  spif_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({ce_ni, sck_i, si_i}),
    .q_o    (pin_q),
    .prev_o (pin_prev)
  );

  assign ce_q     = pin_q[2];
  assign ce_prev  = pin_prev[2];
  assign sck_q    = pin_q[1];
  assign sck_prev = pin_prev[1];
  assign si_q     = pin_q[0];
  assign ce_rise  = ce_q && !ce_prev;
  assign sck_rise = sck_q && !sck_prev;
  assign sck_fall = !sck_q && sck_prev;
  assign status   = status_byte(bp_i, wel, busy);

  spif_shift u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ce_q_i     (ce_q),
    .sck_rise_i (sck_rise),
    .sck_fall_i (sck_fall),
    .si_q_i     (si_q),
    .status_i   (status),
    .opcode_o   (opcode),
    .bits_o     (bits),
    .so_o       (so_o),
    .so_oe_o    (so_oe_o)
  );

  spif_ctrl #(.TCE_CYCLES(TCE_CYCLES)) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ce_rise_i     (ce_rise),
    .opcode_i      (opcode),
    .bits_i        (bits),
    .bp_i          (bp_i),
    .busy_o        (busy),
    .wel_o         (wel),
    .erase_start_o (erase_start),
    .erase_done_o  (erase_done)
  );

  spif_array #(.DEPTH(ARR_DEPTH)) u_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .erase_i (erase_done),
    .we_i    (arr_we_i),
    .addr_i  (arr_addr_i),
    .wdata_i (arr_wdata_i),
    .rdata_o (arr_rdata_o)
  );
endmodule

// File: rtl/spif_cmd_ctrl_chk.sv
module spif_cmd_ctrl_chk
  import spif_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            ce_q,
  input logic            ce_prev,
  input logic            so_oe_o,
  input logic [BP_W-1:0] bp_i,
  input logic            busy,
  input logic            wel,
  input logic            erase_start,
  input logic            erase_done
);
  a_r5_oe_off_ce_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_q && ce_prev) |-> !so_oe_o);

  a_r8_start_needs_wel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_start |-> (wel && bp_i == '0 && !busy));

  a_r7_start_sets_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_start |=> busy);

  a_r9_done_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_done |=> (!busy && !wel));

  a_r10_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !erase_done) |=> busy);

  a_r10_wel_steady_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !erase_done) |=> $stable(wel));
endmodule

bind spif_cmd_ctrl spif_cmd_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ce_q        (ce_q),
  .ce_prev     (ce_prev),
  .so_oe_o     (so_oe_o),
  .bp_i        (bp_i),
  .busy        (busy),
  .wel         (wel),
  .erase_start (erase_start),
  .erase_done  (erase_done)
);

// File: tb/spif_cmd_ctrl_bench.sv
module spif_cmd_ctrl_bench;
  localparam int TCE   = 3000;
  localparam int DEPTH = 16;
  localparam int AW    = $clog2(DEPTH);
  localparam int H     = 8;

  logic          clk = 0, rst_ni = 0;
  logic          ce_ni = 1, sck_i = 0, si_i = 0;
  logic          so_o, so_oe_o;
  logic [3:0]    bp_i = 0;
  logic          arr_we_i = 0;
  logic [AW-1:0] arr_addr_i = 0;
  logic [7:0]    arr_wdata_i = 0, arr_rdata_o;

  int checks = 0, errors = 0, cyc = 0;
  logic       m_wel = 0, m_busy = 0;
  int         m_start = 0;
  logic [7:0] m_mem [DEPTH];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spif_cmd_ctrl #(.TCE_CYCLES(TCE), .ARR_DEPTH(DEPTH)) u_spif_cmd_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .ce_ni(ce_ni), .sck_i(sck_i), .si_i(si_i),
    .so_o(so_o), .so_oe_o(so_oe_o), .bp_i(bp_i), .arr_we_i(arr_we_i),
    .arr_addr_i(arr_addr_i), .arr_wdata_i(arr_wdata_i), .arr_rdata_o(arr_rdata_o)
  );

  always @(posedge clk) if (cyc > 190000) begin
    errors++;
    $display("FAIL watchdog: actual cycle %0d expected below 190000", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status();
    return {2'b00, bp_i, m_wel, m_busy};
  endfunction

  task automatic spi_begin(bit m3);
    sck_i = m3; wt(H);
    ce_ni = 0;  wt(H);
  endtask

  task automatic send_bits(logic [15:0] v, int n);
    for (int i = 0; i < n; i++) begin
      sck_i = 0; si_i = v[n-1-i]; wt(H);
      chk("R5 oe during opcode", so_oe_o, 0);
      sck_i = 1; wt(H);
    end
  endtask

  task automatic spi_end(bit m3);
    if (!m3) begin sck_i = 0; wt(H); end
    ce_ni = 1; wt(4*H);
    chk("R5 oe with ce high", so_oe_o, 0);
  endtask

  // R6 R7 R8 R11 R12 model
  task automatic model_cmd(logic [7:0] op, int nb);
    if (nb != 8 || m_busy) return;
    if (op == 8'h06) m_wel = 1;
    else if (op == 8'h60 || op == 8'hC7) begin
      if (m_wel && bp_i == 0) begin m_busy = 1; m_start = cyc; end
      else m_wel = 0;
    end
  endtask

  task automatic cmd(logic [7:0] op, int nb, bit m3);
    logic [15:0] v;
    v = (nb == 8) ? {8'h00, op} : (nb == 7) ? {9'h000, op[7:1]} : {7'h00, op, 1'b1};
    spi_begin(m3);
    send_bits(v, nb);
    spi_end(m3);
    model_cmd(op, nb);
  endtask

  task automatic rdsr(int nbytes, bit m3, string req);
    logic [7:0] b, e;
    e = exp_status();
    spi_begin(m3);
    send_bits(16'h0005, 8);
    for (int k = 0; k < nbytes; k++) begin
      b = 0;
      for (int i = 0; i < 8; i++) begin
        sck_i = 0; wt(H);
        b = {b[6:0], so_o};
        chk("R3 oe during status", so_oe_o, 1);
        sck_i = 1; wt(H);
      end
      chk(req, b, e);
    end
    spi_end(m3);
  endtask

  task automatic check_mem(string req);
    for (int a = 0; a < DEPTH; a++) begin
      arr_addr_i = AW'(a); #1;
      chk(req, arr_rdata_o, m_mem[a]);
    end
  endtask

  task automatic preload();
    for (int a = 0; a < DEPTH; a++) begin
      arr_we_i = 1; arr_addr_i = AW'(a); arr_wdata_i = 8'($urandom);
      m_mem[a] = arr_wdata_i; wt(1);
    end
    arr_we_i = 0; wt(1);
  endtask

  task automatic wait_erase();
    while (cyc < m_start + TCE + 64) wt(1);
    m_busy = 0; m_wel = 0;
    for (int a = 0; a < DEPTH; a++) m_mem[a] = 8'hFF;
    rdsr(1, 0, "R9 status after erase");
    check_mem("R9 array all ones");
  endtask

  initial begin
    void'($urandom(32'h5EED_0F1A));
    for (int a = 0; a < DEPTH; a++) m_mem[a] = 8'h00;
    wt(5); rst_ni = 1; wt(5);
    chk("R1 oe after reset", so_oe_o, 0);
    check_mem("R1 array after reset");
    rdsr(1, 0, "R1 status after reset");

    bp_i = 4'b1010;
    rdsr(3, 1, "R4 R2 repeated status mode3");
    rdsr(2, 0, "R3 status mode0");
    bp_i = 0;

    cmd(8'h06, 8, 0);
    rdsr(1, 1, "R6 wel set");

    preload();
    bp_i = 4'b0001;
    cmd(8'h60, 8, 0);
    rdsr(1, 0, "R8 protected erase drops wel");
    check_mem("R8 array kept protected");
    bp_i = 0;
    cmd(8'hC7, 8, 1);
    rdsr(1, 0, "R8 no-wel erase");
    check_mem("R8 array kept no wel");

    cmd(8'h06, 7, 0);
    rdsr(1, 0, "R11 seven bits ignored");
    cmd(8'h06, 9, 1);
    rdsr(1, 0, "R11 nine bits ignored");
    cmd(8'hAB, 8, 0);
    rdsr(1, 0, "R12 unknown opcode");

    cmd(8'h06, 8, 1);
    cmd(8'hC7, 8, 1);
    rdsr(2, 1, "R7 busy after C7");
    bp_i = 4'b0001;
    cmd(8'h60, 8, 0);
    rdsr(1, 0, "R10 erase ignored while busy");
    bp_i = 0;
    check_mem("R10 array untouched mid erase");
    wait_erase();

    preload();
    cmd(8'h06, 8, 0);
    cmd(8'h60, 8, 0);
    rdsr(1, 0, "R7 busy after 60");
    wait_erase();

    for (int it = 0; it < 40; it++) begin
      logic [7:0] op;
      int nb, sel;
      bit m3;
      sel = $urandom_range(0, 9);
      op  = (sel < 4) ? 8'h06 : (sel < 6) ? 8'h60 : (sel < 8) ? 8'hC7 : 8'($urandom);
      if (op == 8'h05) op = 8'h06;
      nb  = ($urandom_range(0, 5) == 0) ? (($urandom_range(0, 1) == 0) ? 7 : 9) : 8;
      m3  = 1'($urandom);
      bp_i = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'h0;
      if (!m_busy && $urandom_range(0, 3) == 0) preload();
      cmd(op, nb, m3);
      rdsr($urandom_range(1, 3), 1'($urandom), "R2 R3 random status");
      if (m_busy) begin
        bp_i = 0;
        wait_erase();
      end else check_mem("R8 random array unchanged");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule